// File: doc/BRIEF.md
# Dual-Drive ATA PIO Cycle Timer

This block times programmed-I/O transfers on one ATA cable that carries two devices, a master and a slave. For every transfer it runs three phases: address setup, an active read or write strobe, and recovery. The strobe and recovery lengths come from the chosen drive's own PIO mode. The address-setup length is shared by both drives and is set by the slower of the two modes present on the cable.

A controller sets the clock-class bit and each drive's mode and presence flag. It then raises `start` together with a drive select and a read/write flag. The block reports the active phase on `addr_valid`, `rd_strobe` and `wr_strobe`. It holds `busy` for the length of the transfer and pulses `done` once recovery has finished. If a request arrives while a transfer is running, the requester keeps `start` high and the block accepts it when the running transfer ends.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset, `addr_valid`, `rd_strobe`, `wr_strobe`, `busy` and `done` are all 0.
- R2: A start is accepted only when `busy` is 0 and the selected drive is present (`drive_sel` 0 selects the master, 1 the slave). Any other start is ignored, so a start with no drive present never begins a transfer.
- R3: An accepted transfer shows the following sequence. First `addr_valid` is high alone for A cycles. Then `addr_valid` and one strobe are high for D cycles. Then `busy` is high with both of those low for R cycles. Then `done` is high and `busy` is low for one cycle. The first address cycle begins on the clock edge after `start` is sampled.
- R4: A depends on `slow_class` and on the numerically smallest mode among the present drives. With `slow_class`=0 (33/66 MHz): mode 0 gives 3, modes 1 and 2 give 2, modes 3 and 4 give 1, and modes 5 to 7 give 3. With `slow_class`=1 (25/50 MHz): modes 0 and 1 give 2, modes 2 to 4 give 1, and modes 5 to 7 give 2.
- R5: D/R depend on the selected drive's own mode. With `slow_class`=0: mode 0 gives 6/11, mode 1 gives 5/6, mode 2 gives 4/2, mode 3 gives 3/2, mode 4 gives 3/1, and modes 5 to 7 give 8/10. With `slow_class`=1: mode 0 gives 5/8, mode 1 gives 4/4, mode 2 gives 3/2, mode 3 gives 2/2, mode 4 gives 2/1, and modes 5 to 7 give 8/8.
- R6: With `write_req`=0 the strobe phase drives `rd_strobe`; with `write_req`=1 it drives `wr_strobe`. Both use the same D and R, and the other strobe stays 0.
- R7: The drive select, the read/write flag, the modes, the presence flags and the clock class are sampled only when a start is accepted. Changes to them during a transfer do not affect it.
- R8: If `start` stays high through a transfer, it is accepted in the `done` cycle, and `addr_valid` of the next transfer is high in the following cycle.
- R9: `done` is high for exactly one cycle per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slow_class | input | 1 | 0 = 33/66 MHz timing class, 1 = 25/50 MHz |
| master_present | input | 1 | Master drive is attached |
| master_mode | input | MODE_W | Master PIO mode (0..4; higher values use the fallback timing) |
| slave_present | input | 1 | Slave drive is attached |
| slave_mode | input | MODE_W | Slave PIO mode |
| drive_sel | input | 1 | 0 = master, 1 = slave |
| start | input | 1 | Transfer request |
| write_req | input | 1 | 1 = write, 0 = read |
| addr_valid | output | 1 | Address phase active (setup and strobe) |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties assume that `start` is a level request that a requester may hold across a transfer, and that every other input may change at any time. The properties only relate the outputs to values latched when a transfer is accepted. The bench drives inputs on the falling clock edge and deliberately changes the select, the read/write flag and the modes in the middle of a transfer. It also raises `start` while no drive is selected or present, so that the accept condition is exercised on both sides.

// File: rtl/pio_timer_pkg.sv
// Package: phase encoding and timing tables shared by the PIO cycle timer.
// Assumes modes above 4 are unknown and use the conservative fallback counts.
package pio_timer_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_DATA  = 3'd2,
        PH_RECOV = 3'd3,
        PH_DONE  = 3'd4
    } pio_phase_t;

    // Address-setup clocks for a shared mode and clock class.
    function automatic int unsigned addr_clocks(int unsigned mode, logic slow);
        if (slow) begin
            if (mode <= 1)      return 2;
            else if (mode <= 4) return 1;
            else                return 2;
        end else begin
            if (mode == 0)      return 3;
            else if (mode <= 2) return 2;
            else if (mode <= 4) return 1;
            else                return 3;
        end
    endfunction

    // Strobe-active clocks for one drive's mode.
    function automatic int unsigned active_clocks(int unsigned mode, logic slow);
        case (mode)
            0: return slow ? 5 : 6;
            1: return slow ? 4 : 5;
            2: return slow ? 3 : 4;
            3: return slow ? 2 : 3;
            4: return slow ? 2 : 3;
            default: return 8;
        endcase
    endfunction

    // Recovery clocks for one drive's mode.
    function automatic int unsigned recovery_clocks(int unsigned mode, logic slow);
        case (mode)
            0: return slow ? 8 : 11;
            1: return slow ? 4 : 6;
            2: return 2;
            3: return 2;
            4: return 1;
            default: return slow ? 8 : 10;
        endcase
    endfunction

endpackage

// File: rtl/pio_drive_timing.sv
// Module: maps one drive's PIO mode to its strobe-active and recovery counts.
// Assumes CNT_W is wide enough for the largest count (11).
module pio_drive_timing
    import pio_timer_pkg::*;
#(
    parameter int MODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              slow_class,
    output logic [CNT_W-1:0]  active_cnt,
    output logic [CNT_W-1:0]  recov_cnt
);

    // Table lookup for this drive.
    always_comb begin
        active_cnt = CNT_W'(active_clocks(int'(mode), slow_class));
        recov_cnt  = CNT_W'(recovery_clocks(int'(mode), slow_class));
    end

endmodule

// File: rtl/pio_addr_select.sv
// Module: picks the slowest (numerically smallest) mode among the present
// drives and maps it to the shared address-setup count.
// Assumes at least one drive is present whenever the count is used.
module pio_addr_select
    import pio_timer_pkg::*;
#(
    parameter int MODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              m_present,
    input  logic [MODE_W-1:0] m_mode,
    input  logic              s_present,
    input  logic [MODE_W-1:0] s_mode,
    input  logic              slow_class,
    output logic [CNT_W-1:0]  setup_cnt
);

    logic [MODE_W-1:0] shared_mode;

    // Minimum over the present drives, then the table lookup.
    always_comb begin
        if (m_present && s_present)
            shared_mode = (m_mode < s_mode) ? m_mode : s_mode;
        else if (m_present)
            shared_mode = m_mode;
        else
            shared_mode = s_mode;
        setup_cnt = CNT_W'(addr_clocks(int'(shared_mode), slow_class));
    end

endmodule

// File: rtl/pio_phase_seq.sv
// Module: three-phase transfer sequencer (setup, strobe, recovery, done).
// Assumes every count is at least 1 and that go is already qualified.
module pio_phase_seq
    import pio_timer_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             go_write,
    input  logic [CNT_W-1:0] setup_cnt,
    input  logic [CNT_W-1:0] active_cnt,
    input  logic [CNT_W-1:0] recov_cnt,
    output logic             addr_valid,
    output logic             rd_strobe,
    output logic             wr_strobe,
    output logic             busy,
    output logic             done
);

    pio_phase_t       phase;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] held_active;
    logic [CNT_W-1:0] held_recov;
    logic             held_write;

    // Phase and down-counter advance; request fields latched on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            remain      <= '0;
            held_active <= '0;
            held_recov  <= '0;
            held_write  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE, PH_DONE: begin
                    if (go) begin
                        phase       <= PH_ADDR;
                        remain      <= setup_cnt - CNT_W'(1);
                        held_active <= active_cnt;
                        held_recov  <= recov_cnt;
                        held_write  <= go_write;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                PH_ADDR: begin
                    if (remain == '0) begin
                        phase  <= PH_DATA;
                        remain <= held_active - CNT_W'(1);
                    end else begin
                        remain <= remain - CNT_W'(1);
                    end
                end
                PH_DATA: begin
                    if (remain == '0) begin
                        phase  <= PH_RECOV;
                        remain <= held_recov - CNT_W'(1);
                    end else begin
                        remain <= remain - CNT_W'(1);
                    end
                end
                PH_RECOV: begin
                    if (remain == '0) phase <= PH_DONE;
                    else              remain <= remain - CNT_W'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Output decode from the current phase.
    always_comb begin
        addr_valid = (phase == PH_ADDR) || (phase == PH_DATA);
        rd_strobe  = (phase == PH_DATA) && !held_write;
        wr_strobe  = (phase == PH_DATA) && held_write;
        busy       = (phase == PH_ADDR) || (phase == PH_DATA) || (phase == PH_RECOV);
        done       = (phase == PH_DONE);
    end

    a_r3_strobe_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_strobe || wr_strobe) |-> $past(addr_valid));
    a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(held_write));
    a_r2_busy_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

endmodule

// File: rtl/pio_cycle_timer.sv
// Module: top of the dual-drive PIO cycle timer. Per-drive strobe and
// recovery counts, shared address setup from the slowest present drive.
// Assumes start is a level request that is held until accepted.
module pio_cycle_timer
    import pio_timer_pkg::*;
#(
    parameter int MODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_class,
    input  logic              master_present,
    input  logic [MODE_W-1:0] master_mode,
    input  logic              slave_present,
    input  logic [MODE_W-1:0] slave_mode,
    input  logic              drive_sel,
    input  logic              start,
    input  logic              write_req,
    output logic              addr_valid,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              busy,
    output logic              done
);

    localparam int NDRV = 2;

    logic [MODE_W-1:0] drv_mode    [NDRV];
    logic [CNT_W-1:0]  drv_active  [NDRV];
    logic [CNT_W-1:0]  drv_recov   [NDRV];
    logic [CNT_W-1:0]  shared_setup;
    logic              sel_present;
    logic              go;

    // Gather per-drive modes into an indexable array.
    always_comb begin
        drv_mode[0] = master_mode;
        drv_mode[1] = slave_mode;
    end

    for (genvar d = 0; d < NDRV; d++) begin : g_drive
        pio_drive_timing #(.MODE_W(MODE_W), .CNT_W(CNT_W)) u_timing (
            .mode       (drv_mode[d]),
            .slow_class (slow_class),
            .active_cnt (drv_active[d]),
            .recov_cnt  (drv_recov[d])
        );
    end

    pio_addr_select #(.MODE_W(MODE_W), .CNT_W(CNT_W)) u_addr (
        .m_present  (master_present),
        .m_mode     (master_mode),
        .s_present  (slave_present),
        .s_mode     (slave_mode),
        .slow_class (slow_class),
        .setup_cnt  (shared_setup)
    );

    // Qualify the request with the selected drive's presence.
    always_comb begin
        sel_present = drive_sel ? slave_present : master_present;
        go          = start && sel_present;
    end

    pio_phase_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .go_write   (write_req),
        .setup_cnt  (shared_setup),
        .active_cnt (drv_active[drive_sel]),
        .recov_cnt  (drv_recov[drive_sel]),
        .addr_valid (addr_valid),
        .rd_strobe  (rd_strobe),
        .wr_strobe  (wr_strobe),
        .busy       (busy),
        .done       (done)
    );

    a_r2_absent_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !sel_present) |=> !busy);
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));

endmodule

// File: tb/pio_cycle_timer_bench.sv
`timescale 1ns/1ps
module pio_cycle_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_class = 1'b0;
    logic       master_present = 1'b0;
    logic [2:0] master_mode = '0;
    logic       slave_present = 1'b0;
    logic [2:0] slave_mode = '0;
    logic       drive_sel = 1'b0;
    logic       start = 1'b0;
    logic       write_req = 1'b0;
    logic       addr_valid, rd_strobe, wr_strobe, busy, done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pio_cycle_timer u_pio_cycle_timer (
        .clk(clk), .rst_n(rst_n), .slow_class(slow_class),
        .master_present(master_present), .master_mode(master_mode),
        .slave_present(slave_present), .slave_mode(slave_mode),
        .drive_sel(drive_sel), .start(start), .write_req(write_req),
        .addr_valid(addr_valid), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .busy(busy), .done(done)
    );

    function automatic int exp_setup(int cls, int m);
        if (cls == 1) return (m <= 1) ? 2 : (m <= 4) ? 1 : 2;
        return (m == 0) ? 3 : (m <= 2) ? 2 : (m <= 4) ? 1 : 3;
    endfunction

    function automatic int exp_active(int cls, int m);
        if (m > 4) return 8;
        if (cls == 1) return (m >= 3) ? 2 : 5 - m;
        return (m >= 3) ? 3 : 6 - m;
    endfunction

    function automatic int exp_recov(int cls, int m);
        if (m > 4) return (cls == 1) ? 8 : 10;
        if (m >= 2) return (m == 4) ? 1 : 2;
        if (cls == 1) return (m == 0) ? 8 : 4;
        return (m == 0) ? 11 : 6;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Measures one transfer starting at the current falling edge (first address cycle).
    task automatic measure(input int ea, input int ed, input int er, input bit ewr);
        int na = 0, nd = 0, nr = 0, order_bad = 0, stage = 0, wrong_strobe = 0;
        bit got_done = 0;
        for (int k = 0; k < 100; k++) begin
            if (done) begin got_done = 1; break; end
            if (addr_valid && !rd_strobe && !wr_strobe) begin
                na++; if (stage > 0) order_bad++;
            end else if (addr_valid && (rd_strobe || wr_strobe)) begin
                nd++; if (stage > 1) order_bad++; stage = 1;
                if (ewr ? (rd_strobe || !wr_strobe) : (wr_strobe || !rd_strobe)) wrong_strobe++;
            end else if (busy) begin
                nr++; stage = 2;
            end else order_bad++;
            @(negedge clk);
        end
        check(got_done, "R3 done reached", got_done, 1);
        check(order_bad == 0, "R3 phase order", order_bad, 0);
        check(na == ea, "R4 setup length", na, ea);
        check(nd == ed, "R5 strobe length", nd, ed);
        check(nr == er, "R5 recovery length", nr, er);
        check(wrong_strobe == 0, "R6 strobe direction", wrong_strobe, 0);
        check(!busy, "R3 busy low with done", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({addr_valid, rd_strobe, wr_strobe, busy, done} == 5'b0, "R1 reset outputs",
              {addr_valid, rd_strobe, wr_strobe, busy, done}, 0);

        // R2: no drive present
        start = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(!busy && !addr_valid, "R2 no drive ignored", busy, 0);
        end
        // R2: selected slave absent
        master_present = 1'b1; drive_sel = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(!busy && !addr_valid, "R2 absent slave ignored", busy, 0);
        end
        start = 1'b0;
        @(negedge clk);

        // R3..R6 sweep across class, selected drive, other presence and both modes
        for (int cls = 0; cls < 2; cls++)
          for (int sel = 0; sel < 2; sel++)
            for (int op = 0; op < 2; op++)
              for (int mm = 0; mm < 8; mm++)
                for (int ms = 0; ms < 8; ms++) begin
                    int shared, own;
                    slow_class = cls[0]; drive_sel = sel[0];
                    master_mode = mm[2:0]; slave_mode = ms[2:0];
                    master_present = (sel == 0) ? 1'b1 : op[0];
                    slave_present  = (sel == 1) ? 1'b1 : op[0];
                    write_req = ((mm + ms) % 2) == 1;
                    own = (sel == 1) ? ms : mm;
                    shared = (master_present && slave_present) ? ((mm < ms) ? mm : ms) : own;
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    measure(exp_setup(cls, shared), exp_active(cls, own), exp_recov(cls, own),
                            write_req);
                    @(negedge clk);
                    check(!done, "R9 done one cycle", done, 0);
                end

        // R7/R8: held start, inputs changed mid-transfer
        slow_class = 1'b0; master_present = 1'b1; slave_present = 1'b1;
        master_mode = 3'd4; slave_mode = 3'd4; drive_sel = 1'b0; write_req = 1'b0;
        start = 1'b1;
        @(negedge clk);
        drive_sel = 1'b1; write_req = 1'b1; slave_mode = 3'd0; master_mode = 3'd1;
        slow_class = 1'b1;
        measure(1, 3, 1, 1'b0);   // R7: first transfer keeps the sampled settings
        @(negedge clk);
        check(addr_valid, "R8 back-to-back setup", addr_valid, 1);
        start = 1'b0;
        measure(2, 5, 8, 1'b1);   // second transfer: slave mode 0, slow class, write
        @(negedge clk);
        check(!done && !busy, "R9 idle after second", busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule